// File: doc/BRIEF.md
# Segmented virtual address translator

The block turns a 32-bit virtual address into a physical address with a few attributes. The top three address bits pick one of five regions: a 2 GB low region that both user and privileged code may use, and four 512 MB privileged regions. Two independent configuration bits control translation. One turns on the fixed folding of three privileged regions onto the bottom 512 MB of physical space. The other sends mapped addresses to an external page lookup port. Together they give four translation modes.

A requester offers one address at a time on a valid/ready input, together with a privilege bit. Unprivileged accesses outside the low region are refused with an error before any page lookup is started. Addresses that need a page lookup leave through a valid/ready request port. The matching response brings back a physical address or a miss. Every accepted request produces exactly one result pulse. That pulse carries the physical address, a cacheable flag, a translated flag and the error and miss indications.

Top module: `segx_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and pl_req_valid are 0, segment folding is enabled and paging is disabled.
- R2: For a result with no error and no miss, rsp_cacheable is 0 when vaddr[31:29] is 101 or 111, and 1 for every other value of vaddr[31:29].
- R3: With folding off and paging off, every address returns rsp_paddr equal to the virtual address, with rsp_xlat 0 and no page lookup.
- R4: With folding on and paging off, vaddr[31:29] equal to 100, 101 or 110 returns the address with bits [31:29] cleared and rsp_xlat 1. Values 0xx and 111 return the address unchanged with rsp_xlat 0. No page lookup is made.
- R5: With folding off and paging on, every address is sent to the page lookup. The lookup result supplies rsp_paddr, with rsp_xlat 1.
- R6: With both enabled, 100 and 101 are folded (rsp_xlat 1) and 111 is returned unchanged (rsp_xlat 0), all without a lookup. Values 0xx and 110 are sent to the page lookup, whose result supplies rsp_paddr.
- R7: When req_priv is 0 and vaddr[31] is 1, in every mode, the result has rsp_err 1, rsp_paddr 0, rsp_cacheable 0, rsp_xlat 0 and rsp_miss 0. No page lookup is issued.
- R8: A lookup response with pl_rsp_miss 1 gives rsp_miss 1, rsp_miss_addr equal to the virtual address, rsp_paddr 0, rsp_xlat 0, rsp_cacheable 0 and rsp_err 0.
- R9: A result that needs no lookup appears on rsp_valid one cycle after the request is accepted, and requests may be accepted on consecutive cycles. A looked-up result appears one cycle after pl_rsp_valid. req_ready is 0 while a lookup is outstanding.
- R10: pl_req_valid stays asserted and pl_req_vaddr stays equal to the requested virtual address until pl_req_ready is seen.
- R11: cfg_we loads both enables. A request accepted in the same cycle as the write uses the old enables. Requests accepted later use the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the two enable bits |
| cfg_seg_en | input | 1 | New segment folding enable |
| cfg_page_en | input | 1 | New paging enable |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_priv | input | 1 | 1 for a privileged access |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_xlat | output | 1 | Address was folded or page-mapped |
| rsp_err | output | 1 | Privilege violation |
| rsp_miss | output | 1 | Page lookup missed |
| rsp_miss_addr | output | 32 | Virtual address that missed |
| pl_req_valid | output | 1 | Page lookup request |
| pl_req_ready | input | 1 | Page lookup accepts the request |
| pl_req_vaddr | output | 32 | Address to look up |
| pl_rsp_valid | input | 1 | Page lookup response |
| pl_rsp_paddr | input | 32 | Looked-up physical address |
| pl_rsp_miss | input | 1 | No mapping found |

## Verification
A configuration write and a request acceptance can fall in the same cycle. The request must then be translated with the old enables while the next one sees the new ones. The bench provokes this by raising cfg_we together with a request in the folded region and keeping the request port busy one more cycle with the same address. It then judges the two consecutive result pulses: the first must be folded and the second returned unchanged. A full sweep over all four modes, every segment code, both privilege levels and hit and miss lookups is judged against addresses computed arithmetically.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEG_W = 3;

  typedef enum logic [2:0] {
    SEG_LOW = 3'b000,
    SEG_P1  = 3'b100,
    SEG_P2  = 3'b101,
    SEG_P3  = 3'b110,
    SEG_P4  = 3'b111
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  typedef struct packed {
    logic err;
    logic need_page;
    logic cach;
    logic xlat;
  } attr_t;

  function automatic seg_e seg_of(input logic [SEG_W-1:0] s);
    case (s)
      3'b100:  return SEG_P1;
      3'b101:  return SEG_P2;
      3'b110:  return SEG_P3;
      3'b111:  return SEG_P4;
      default: return SEG_LOW;
    endcase
  endfunction
endpackage

// File: rtl/segx_cfg.sv
module segx_cfg (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic seg_in,
  input  logic page_in,
  output logic seg_en,
  output logic page_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_en  <= 1'b1;
      page_en <= 1'b0;
    end else if (we) begin
      seg_en  <= seg_in;
      page_en <= page_in;
    end
  end
endmodule

// File: rtl/segx_decode.sv
module segx_decode
  import segx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] vaddr,
  input  logic          priv,
  input  logic          seg_en,
  input  logic          page_en,
  output attr_t         attr,
  output logic [AW-1:0] paddr
);
  localparam int LSB = AW - SEG_W;

  seg_e          seg;
  logic [AW-1:0] folded;

  assign seg    = seg_of(vaddr[AW-1:LSB]);
  assign folded = {{SEG_W{1'b0}}, vaddr[LSB-1:0]};

  always_comb begin
    attr.err       = !priv && (seg != SEG_LOW);
    attr.cach      = !((seg == SEG_P2) || (seg == SEG_P4));
    attr.need_page = 1'b0;
    attr.xlat      = 1'b0;
    paddr          = vaddr;
    if (attr.err) begin
      attr.cach = 1'b0;
      paddr     = '0;
    end else if (!seg_en) begin
      attr.need_page = page_en;
    end else begin
      case (seg)
        SEG_P1, SEG_P2: begin
          paddr     = folded;
          attr.xlat = 1'b1;
        end
        SEG_P3: begin
          if (page_en) begin
            attr.need_page = 1'b1;
          end else begin
            paddr     = folded;
            attr.xlat = 1'b1;
          end
        end
        SEG_LOW: attr.need_page = page_en;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  attr_t         dec_attr,
  input  logic [AW-1:0] dec_paddr,
  output logic          pl_req_valid,
  input  logic          pl_req_ready,
  output logic [AW-1:0] pl_req_vaddr,
  input  logic          pl_rsp_valid,
  input  logic [AW-1:0] pl_rsp_paddr,
  input  logic          pl_rsp_miss,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_cacheable,
  output logic          rsp_xlat,
  output logic          rsp_err,
  output logic          rsp_miss,
  output logic [AW-1:0] rsp_miss_addr
);
  st_e           state;
  logic          held_cach;
  logic [AW-1:0] held_va;
  logic          accept;

  assign req_ready    = (state == ST_IDLE);
  assign pl_req_valid = (state == ST_ISSUE);
  assign pl_req_vaddr = held_va;
  assign accept       = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      held_cach     <= 1'b0;
      held_va       <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
      rsp_xlat      <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_miss      <= 1'b0;
      rsp_miss_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (dec_attr.need_page) begin
              state     <= ST_ISSUE;
              held_va   <= req_vaddr;
              held_cach <= dec_attr.cach;
            end else begin
              rsp_valid     <= 1'b1;
              rsp_paddr     <= dec_paddr;
              rsp_cacheable <= dec_attr.cach;
              rsp_xlat      <= dec_attr.xlat;
              rsp_err       <= dec_attr.err;
              rsp_miss      <= 1'b0;
              rsp_miss_addr <= '0;
            end
          end
        end
        ST_ISSUE: begin
          if (pl_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (pl_rsp_valid) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_miss  <= pl_rsp_miss;
            if (pl_rsp_miss) begin
              rsp_paddr     <= '0;
              rsp_cacheable <= 1'b0;
              rsp_xlat      <= 1'b0;
              rsp_miss_addr <= held_va;
            end else begin
              rsp_paddr     <= pl_rsp_paddr;
              rsp_cacheable <= held_cach;
              rsp_xlat      <= 1'b1;
              rsp_miss_addr <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_seg_en,
  input  logic          cfg_page_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_priv,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_cacheable,
  output logic          rsp_xlat,
  output logic          rsp_err,
  output logic          rsp_miss,
  output logic [AW-1:0] rsp_miss_addr,
  output logic          pl_req_valid,
  input  logic          pl_req_ready,
  output logic [AW-1:0] pl_req_vaddr,
  input  logic          pl_rsp_valid,
  input  logic [AW-1:0] pl_rsp_paddr,
  input  logic          pl_rsp_miss
);
  logic          seg_en;
  logic          page_en;
  attr_t         dec_attr;
  logic [AW-1:0] dec_paddr;

  segx_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .seg_in  (cfg_seg_en),
    .page_in (cfg_page_en),
    .seg_en  (seg_en),
    .page_en (page_en)
  );

  segx_decode #(.AW(AW)) u_dec (
    .vaddr   (req_vaddr),
    .priv    (req_priv),
    .seg_en  (seg_en),
    .page_en (page_en),
    .attr    (dec_attr),
    .paddr   (dec_paddr)
  );

  segx_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .dec_attr      (dec_attr),
    .dec_paddr     (dec_paddr),
    .pl_req_valid  (pl_req_valid),
    .pl_req_ready  (pl_req_ready),
    .pl_req_vaddr  (pl_req_vaddr),
    .pl_rsp_valid  (pl_rsp_valid),
    .pl_rsp_paddr  (pl_rsp_paddr),
    .pl_rsp_miss   (pl_rsp_miss),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_cacheable (rsp_cacheable),
    .rsp_xlat      (rsp_xlat),
    .rsp_err       (rsp_err),
    .rsp_miss      (rsp_miss),
    .rsp_miss_addr (rsp_miss_addr)
  );
endmodule

// File: rtl/segx_chk.sv
module segx_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_vaddr,
  input logic          req_priv,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_cacheable,
  input logic          rsp_xlat,
  input logic          rsp_err,
  input logic          rsp_miss,
  input logic [AW-1:0] rsp_miss_addr,
  input logic          pl_req_valid,
  input logic          pl_req_ready,
  input logic [AW-1:0] pl_req_vaddr,
  input logic          pl_rsp_valid,
  input logic          pl_rsp_miss
);
  logic [AW-1:0] acc_va;
  logic          pending;
  logic [2:0]    acc_top;

  assign acc_top = acc_va[AW-1:AW-3];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_va  <= '0;
      pending <= 1'b0;
    end else begin
      if (req_valid && req_ready) acc_va <= req_vaddr;
      if (pl_req_valid && pl_req_ready) pending <= 1'b1;
      else if (pl_rsp_valid) pending <= 1'b0;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> req_ready && !rsp_valid && !pl_req_valid) // R1
    else $error("reset state wrong");

  AST_UNCACHED_SEG: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_err && (acc_top == 3'b101 || acc_top == 3'b111) |-> !rsp_cacheable) // R2
    else $error("uncacheable segment reported cacheable");

  AST_PRIV_ERR: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_priv && req_vaddr[AW-1] |=> rsp_valid && rsp_err && !pl_req_valid) // R7
    else $error("privilege violation not flagged");

  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_paddr == '0 && !rsp_cacheable && !rsp_xlat && !rsp_miss) // R7
    else $error("error result not clean");

  AST_MISS_ADDR: assert property (@(posedge clk) disable iff (rst)
    pending && pl_rsp_valid && pl_rsp_miss |=> rsp_valid && rsp_miss && rsp_miss_addr == acc_va && !rsp_err) // R8
    else $error("miss not reported");

  AST_PAGED_LAT: assert property (@(posedge clk) disable iff (rst)
    pending && pl_rsp_valid |=> rsp_valid) // R9
    else $error("paged result late");

  AST_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pl_req_valid || pending) |-> !req_ready) // R9
    else $error("ready while lookup outstanding");

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    pl_req_valid && !pl_req_ready |=> pl_req_valid && $stable(pl_req_vaddr)) // R10
    else $error("lookup request dropped");

  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (rst)
    pl_req_valid |-> pl_req_vaddr == acc_va) // R10
    else $error("lookup address wrong");
endmodule

bind segx_top segx_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .req_priv      (req_priv),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_cacheable (rsp_cacheable),
  .rsp_xlat      (rsp_xlat),
  .rsp_err       (rsp_err),
  .rsp_miss      (rsp_miss),
  .rsp_miss_addr (rsp_miss_addr),
  .pl_req_valid  (pl_req_valid),
  .pl_req_ready  (pl_req_ready),
  .pl_req_vaddr  (pl_req_vaddr),
  .pl_rsp_valid  (pl_rsp_valid),
  .pl_rsp_miss   (pl_rsp_miss)
);

// File: tb/tb_segx_top.sv
`timescale 1ns/1ps
module tb_segx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_seg_en = 1'b0, cfg_page_en = 1'b0;
  logic        req_valid = 1'b0, req_priv = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_cacheable, rsp_xlat, rsp_err, rsp_miss;
  logic [31:0] rsp_paddr, rsp_miss_addr, pl_req_vaddr;
  logic        pl_req_valid;
  logic        pl_req_ready = 1'b0, pl_rsp_valid = 1'b0, pl_rsp_miss = 1'b0;
  logic [31:0] pl_rsp_paddr = '0;

  int total = 0, bad = 0, cyc = 0, nlook = 0, rsp_cyc = -1;
  logic [31:0] lk_va;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  segx_top dut (.*);

  function automatic logic [31:0] page_map(input logic [31:0] va);
    return {va[31:12] ^ 20'h5A3C1, va[11:0]};
  endfunction
  function automatic logic page_miss(input logic [31:0] va);
    return va[13:12] == 2'b11;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // page lookup responder with varying delays
  initial begin
    forever begin
      @(negedge clk);
      if (pl_req_valid) begin
        repeat (nlook % 3) @(negedge clk);
        pl_req_ready = 1'b1;
        lk_va = pl_req_vaddr;
        @(negedge clk);
        pl_req_ready = 1'b0;
        nlook++;
        repeat (nlook % 2) @(negedge clk);
        pl_rsp_valid = 1'b1;
        pl_rsp_paddr = page_map(lk_va);
        pl_rsp_miss  = page_miss(lk_va);
        rsp_cyc = cyc + 1;
        @(negedge clk);
        pl_rsp_valid = 1'b0;
      end
    end
  end

  task automatic set_mode(input logic s, input logic p);
    cfg_we = 1'b1; cfg_seg_en = s; cfg_page_en = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issues one request from a negedge and checks the result against the expectation
  task automatic run_req(input logic s, input logic p, input logic priv, input logic [31:0] va);
    logic [2:0] top;
    logic e_err, e_np, e_cach, e_xl, e_miss;
    logic [31:0] e_pa;
    int n, look0;
    string tag;
    top = va[31:29];
    e_err = !priv && top[2];
    e_cach = !(top == 3'd5 || top == 3'd7);
    e_np = 1'b0; e_xl = 1'b0; e_pa = va; e_miss = 1'b0;
    if (e_err) begin e_cach = 1'b0; e_pa = '0; end
    else if (!s) e_np = p;
    else if (!top[2]) e_np = p;
    else if (top == 3'd4 || top == 3'd5) begin e_pa = {3'b000, va[28:0]}; e_xl = 1'b1; end
    else if (top == 3'd6) begin
      if (p) e_np = 1'b1; else begin e_pa = {3'b000, va[28:0]}; e_xl = 1'b1; end
    end
    if (e_np) begin
      e_miss = page_miss(va);
      e_pa   = e_miss ? 32'h0 : page_map(va);
      e_xl   = !e_miss;
      if (e_miss) e_cach = 1'b0;
    end
    if (e_err) tag = "R7";
    else if (e_miss) tag = "R8";
    else if (!s && !p) tag = "R3";
    else if (s && !p) tag = "R4";
    else if (!s && p) tag = "R5";
    else tag = "R6";

    look0 = nlook;
    chk(req_ready == 1'b1, "R9", "ready before request", {63'b0, req_ready}, 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_priv = priv;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, "R9", "result present", {63'b0, rsp_valid}, 64'd1);
    if (!e_np) chk(n == 1, "R9", "unpaged latency", 64'(n), 64'd1);
    else chk(cyc == rsp_cyc, "R9", "paged latency", 64'(cyc), 64'(rsp_cyc));
    if (e_np) chk(lk_va == va, "R10", "lookup address", {32'b0, lk_va}, {32'b0, va});
    chk((nlook - look0) == int'(e_np), tag, "lookup count", 64'(nlook - look0), 64'(e_np));
    chk(rsp_paddr == e_pa, tag, "paddr", {32'b0, rsp_paddr}, {32'b0, e_pa});
    chk(rsp_xlat == e_xl, tag, "xlat", {63'b0, rsp_xlat}, {63'b0, e_xl});
    chk(rsp_err == e_err, tag, "err", {63'b0, rsp_err}, {63'b0, e_err});
    chk(rsp_miss == e_miss, tag, "miss", {63'b0, rsp_miss}, {63'b0, e_miss});
    if (e_miss) chk(rsp_miss_addr == va, "R8", "miss addr", {32'b0, rsp_miss_addr}, {32'b0, va});
    chk(rsp_cacheable == e_cach, (e_err || e_miss) ? tag : "R2", "cacheable",
        {63'b0, rsp_cacheable}, {63'b0, e_cach});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [28:0] lows [4];
    lows[0] = 29'h0000_0000;
    lows[1] = 29'h1FFF_FFFF;
    lows[2] = 29'h0ABC_3123;
    lows[3] = 29'h0555_1456;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and default enables
    chk(req_ready == 1'b1, "R1", "req_ready after reset", {63'b0, req_ready}, 64'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
    chk(pl_req_valid == 1'b0, "R1", "pl_req_valid after reset", {63'b0, pl_req_valid}, 64'd0);
    run_req(1'b1, 1'b0, 1'b1, 32'h9000_0040);  // R1 fold on by default
    run_req(1'b1, 1'b0, 1'b1, 32'h0000_3000);  // R1 paging off by default

    // R11: config write in the same cycle as an accept, then back-to-back request
    cfg_we = 1'b1; cfg_seg_en = 1'b0; cfg_page_en = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'h8123_4567; req_priv = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(rsp_valid && rsp_paddr == 32'h0123_4567, "R11", "old enables used",
        {32'b0, rsp_paddr}, 64'h0123_4567);
    chk(req_ready == 1'b1, "R9", "ready for back-to-back", {63'b0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_paddr == 32'h8123_4567 && !rsp_xlat, "R11", "new enables used",
        {32'b0, rsp_paddr}, 64'h8123_4567);
    @(negedge clk);

    // sweep: all modes, segment codes, privilege levels and low patterns
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      for (int t = 0; t < 8; t++)
        for (int pv = 0; pv < 2; pv++)
          for (int l = 0; l < 4; l++)
            run_req(m[1], m[0], pv[0], {t[2:0], lows[l]});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule